// File: doc/BRIEF.md
# Even/Odd Lane Widening Vector Multiplier

This block multiplies half of the elements of two 128-bit vector operands and widens every product to twice the element width, so the products exactly fill a 128-bit result. The caller chooses the element size (byte or halfword), whether the even-indexed or the odd-indexed elements take part, and whether the elements are signed or unsigned. Each lane's product is kept at full width, with no truncation and no saturation.

An operation is launched by presenting both operands and the three mode controls with `in_valid` high for one cycle. The result is registered. It appears together with `out_valid` on the following cycle and stays on `result` until the next launch, so a consumer may read it at any later point. Launches may be issued back to back, one per cycle.

Top module: `vec_widen_mul`

## Requirements
- R1: Elements are numbered from the most significant end. Byte element k of an operand is bits [127-8k -: 8], halfword element k is bits [127-16k -: 16], and result lane 0 is the most significant lane.
- R2: With `half_mode`=0 (byte size) the result holds 8 lanes of 16 bits, lane i at bits [127-16i -: 16]. With `half_mode`=1 (halfword size) it holds 4 lanes of 32 bits, lane i at bits [127-32i -: 32].
- R3: With `odd_sel`=0, result lane i is the product of element 2i of `op_a` and element 2i of `op_b`.
- R4: With `odd_sel`=1, result lane i is the product of element 2i+1 of `op_a` and element 2i+1 of `op_b`.
- R5: With `signed_mode`=0, elements are zero-extended before the multiply (for example 0xFF times 0x01 gives 0x00FF).
- R6: With `signed_mode`=1, elements are sign-extended and the lane holds the two's-complement product (for example 0xFF times 0x01 gives 0xFFFF).
- R7: Products keep their full double width with no truncation or saturation. Byte unsigned 0xFF*0xFF gives 0xFE01, byte signed 0x80*0x80 gives 0x4000, halfword unsigned 0xFFFF*0xFFFF gives 0xFFFE0001, and halfword signed 0x8000*0x8000 gives 0x40000000.
- R8: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high.
- R9: While `in_valid` is low, `result` keeps its last value, whatever the operand and mode inputs do.
- R10: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Launch strobe for one operation |
| op_a | input | 128 | First vector operand |
| op_b | input | 128 | Second vector operand |
| half_mode | input | 1 | Element size: 0 byte, 1 halfword |
| odd_sel | input | 1 | Element pick: 0 even, 1 odd |
| signed_mode | input | 1 | 0 unsigned, 1 signed |
| out_valid | output | 1 | Result produced by the previous cycle's launch |
| result | output | 128 | Widened products, held between launches |

## Verification
A counting pattern gives each element a distinct value. A product from the wrong parity, or one placed in the wrong lane, therefore shows a different number, which separates even from odd selection and exposes lane-order faults in both sizes. All-ones times one separates zero extension from sign extension. All-ones squared and most-negative squared in each size test the widest products against truncation and saturation. Random operands in all eight mode combinations are issued back to back, and each is followed by idle cycles with changing inputs to show that the result holds.

// File: rtl/vwm_pkg.sv
package vwm_pkg;
  localparam int unsigned VEC_W_DEF  = 128;
  localparam int unsigned ELEM_W_DEF = 8;

  typedef enum logic {
    SIZE_BYTE = 1'b0,
    SIZE_HALF = 1'b1
  } elem_size_e;
endpackage

// File: rtl/vwm_pick.sv
// Picks the upper (even) or lower (odd) element of a double-width pair
// and extends it by one bit according to the signedness control.
module vwm_pick #(
  parameter int unsigned EW = 8
) (
  input  logic [2*EW-1:0] pair,
  input  logic            odd_sel,
  input  logic            sgn,
  output logic [EW:0]     ext
);
  logic [EW-1:0] sel;

  always_comb begin
    sel = odd_sel ? pair[EW-1:0] : pair[2*EW-1:EW];
    ext = {sgn & sel[EW-1], sel};
  end
endmodule

// File: rtl/vwm_lane_mul.sv
// Signed multiply of two (EW+1)-bit extended elements. The product always
// fits in 2*EW bits, so only the low 2*EW bits are formed.
module vwm_lane_mul #(
  parameter int unsigned EW = 8
) (
  input  logic [EW:0]     a,
  input  logic [EW:0]     b,
  output logic [2*EW-1:0] prod
);
  localparam int unsigned PW = 2 * EW;

  logic signed [PW-1:0] sa;
  logic signed [PW-1:0] sb;

  always_comb begin
    sa   = {{(PW-EW-1){a[EW]}}, a};
    sb   = {{(PW-EW-1){b[EW]}}, b};
    prod = sa * sb;
  end
endmodule

// File: rtl/vwm_lane_bank.sv
// One multiplier per result lane for a single element size.
module vwm_lane_bank #(
  parameter int unsigned VEC_W = 128,
  parameter int unsigned EW    = 8
) (
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic             odd_sel,
  input  logic             sgn,
  output logic [VEC_W-1:0] res
);
  localparam int unsigned LANE_W  = 2 * EW;
  localparam int unsigned N_LANES = VEC_W / LANE_W;

  for (genvar i = 0; i < N_LANES; i++) begin : g_lane
    localparam int unsigned TOP = VEC_W - 1 - LANE_W * i;
    logic [EW:0]       ea;
    logic [EW:0]       eb;
    logic [LANE_W-1:0] p;

    vwm_pick #(.EW(EW)) u_pick_a (
      .pair(op_a[TOP -: LANE_W]), .odd_sel(odd_sel), .sgn(sgn), .ext(ea)
    );
    vwm_pick #(.EW(EW)) u_pick_b (
      .pair(op_b[TOP -: LANE_W]), .odd_sel(odd_sel), .sgn(sgn), .ext(eb)
    );
    vwm_lane_mul #(.EW(EW)) u_mul (
      .a(ea), .b(eb), .prod(p)
    );

    assign res[TOP -: LANE_W] = p;
  end
endmodule

// File: rtl/vec_widen_mul.sv
module vec_widen_mul
  import vwm_pkg::*;
#(
  parameter int unsigned VEC_W  = VEC_W_DEF,
  parameter int unsigned ELEM_W = ELEM_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic             half_mode,
  input  logic             odd_sel,
  input  logic             signed_mode,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  localparam int unsigned HALF_W = 2 * ELEM_W;
  localparam int unsigned WORD_W = 2 * HALF_W;

  elem_size_e       size;
  logic [VEC_W-1:0] byte_res;
  logic [VEC_W-1:0] half_res;
  logic [VEC_W-1:0] res_d;
  logic [VEC_W-1:0] res_q;
  logic             vld_d;
  logic             vld_q;

  assign size = elem_size_e'(half_mode);

  vwm_lane_bank #(.VEC_W(VEC_W), .EW(ELEM_W)) u_bank_byte (
    .op_a(op_a), .op_b(op_b), .odd_sel(odd_sel), .sgn(signed_mode),
    .res(byte_res)
  );

  vwm_lane_bank #(.VEC_W(VEC_W), .EW(HALF_W)) u_bank_half (
    .op_a(op_a), .op_b(op_b), .odd_sel(odd_sel), .sgn(signed_mode),
    .res(half_res)
  );

  // next-state
  always_comb begin
    vld_d = in_valid;
    res_d = res_q;
    if (in_valid) begin
      res_d = (size == SIZE_HALF) ? half_res : byte_res;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R9
  AST_EVEN_ZERO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !half_mode && !odd_sel && (op_a[VEC_W-1 -: ELEM_W] == '0))
    |=> (result[VEC_W-1 -: HALF_W] == '0)); // R3
  AST_SIGNED_MINUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && signed_mode && half_mode && odd_sel &&
     (op_a[VEC_W-1-HALF_W -: HALF_W] == '1) &&
     (op_b[VEC_W-1-HALF_W -: HALF_W] == HALF_W'(1)))
    |=> (result[VEC_W-1 -: WORD_W] == '1)); // R6
endmodule

// File: tb/sim_vec_widen_mul.sv
module sim_vec_widen_mul;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] op_a = '0;
  logic [127:0] op_b = '0;
  logic         half_mode = 1'b0;
  logic         odd_sel = 1'b0;
  logic         signed_mode = 1'b0;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0;
  int failures = 0;
  bit mon_on = 1'b0;
  bit have_last = 1'b0;
  logic [127:0] last_exp = '0;
  logic [127:0] exp_q[$];
  string        tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  vec_widen_mul u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .half_mode(half_mode), .odd_sel(odd_sel), .signed_mode(signed_mode),
    .out_valid(out_valid), .result(result)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%032h expected=%032h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [127:0] a,
      input logic [127:0] b, input logic h, input logic o, input logic s);
    logic [127:0] r = '0;
    if (!h) begin
      for (int i = 0; i < 8; i++) begin
        int k = 2 * i + int'(o);
        logic signed [8:0]  ea = {s & a[127-8*k], a[127-8*k -: 8]};
        logic signed [8:0]  eb = {s & b[127-8*k], b[127-8*k -: 8]};
        logic signed [17:0] p = ea * eb;
        r[127-16*i -: 16] = p[15:0];
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        int k = 2 * i + int'(o);
        logic signed [16:0] ea = {s & a[127-16*k], a[127-16*k -: 16]};
        logic signed [16:0] eb = {s & b[127-16*k], b[127-16*k -: 16]};
        logic signed [33:0] p = ea * eb;
        r[127-32*i -: 32] = p[31:0];
      end
    end
    return r;
  endfunction

  // driver: one launch with a given expected value
  task automatic send_exp(input logic [127:0] a, input logic [127:0] b,
      input logic h, input logic o, input logic s,
      input logic [127:0] exp, input string tag);
    @(negedge clk);
    #1;
    op_a = a; op_b = b; half_mode = h; odd_sel = o; signed_mode = s;
    in_valid = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [127:0] a, input logic [127:0] b,
      input logic h, input logic o, input logic s, input string tag);
    send_exp(a, b, h, o, s, model(a, b, h, o, s), tag);
  endtask

  // idle cycles with changing, ignored inputs
  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      #1;
      in_valid = 1'b0;
      op_a = {$urandom, $urandom, $urandom, $urandom};
      op_b = {$urandom, $urandom, $urandom, $urandom};
      half_mode = 1'($urandom); odd_sel = 1'($urandom);
      signed_mode = 1'($urandom);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      check(out_valid == (exp_q.size() > 0), "R8 out_valid timing",
            128'(out_valid), 128'(exp_q.size() > 0));
      if (out_valid && exp_q.size() > 0) begin
        last_exp = exp_q.pop_front();
        check(result == last_exp, tag_q.pop_front(), result, last_exp);
        have_last = 1'b1;
      end else if (!out_valid && have_last) begin
        check(result == last_exp, "R9 result held while idle",
              result, last_exp);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && result == '0, "R10 reset state",
          result, '0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #2 mon_on = 1'b1;

    // R1 R3: counting bytes, even picks elements 0,2,..,14 (values 1,3,..)
    send_exp(128'h0102030405060708090A0B0C0D0E0F10, {16{8'h02}}, 0, 0, 0,
             128'h00020006000A000E00120016001A001E, "R1 R3 byte even order");
    // R4: odd picks elements 1,3,..,15
    send_exp(128'h0102030405060708090A0B0C0D0E0F10, {16{8'h02}}, 0, 1, 0,
             128'h000400080_00C00100014001800_1C0020 | 128'h0,
             "R4 byte odd order");
    idle(2);
    // R2 R3 R4: halfword lanes
    send_exp(128'h00010002000300040005000600070008, {8{16'h0003}}, 1, 0, 0,
             128'h00000003_00000009_0000000F_00000015, "R2 R3 half even");
    send_exp(128'h00010002000300040005000600070008, {8{16'h0003}}, 1, 1, 0,
             128'h00000006_0000000C_00000012_00000018, "R2 R4 half odd");
    idle(2);
    // R5 R6: zero vs sign extension
    send_exp({16{8'hFF}}, {16{8'h01}}, 0, 0, 0, {8{16'h00FF}},
             "R5 byte unsigned extend");
    send_exp({16{8'hFF}}, {16{8'h01}}, 0, 1, 1, {8{16'hFFFF}},
             "R6 byte signed extend");
    send_exp({8{16'hFFFF}}, {8{16'h0001}}, 1, 1, 1, {4{32'hFFFFFFFF}},
             "R6 half signed extend");
    send_exp({8{16'hFFFF}}, {8{16'h0001}}, 1, 0, 0, {4{32'h0000FFFF}},
             "R5 half unsigned extend");
    idle(3);
    // R7: widest products
    send_exp({16{8'hFF}}, {16{8'hFF}}, 0, 0, 0, {8{16'hFE01}},
             "R7 byte unsigned max");
    send_exp({16{8'h80}}, {16{8'h80}}, 0, 1, 1, {8{16'h4000}},
             "R7 byte signed min");
    send_exp({8{16'hFFFF}}, {8{16'hFFFF}}, 1, 0, 0, {4{32'hFFFE0001}},
             "R7 half unsigned max");
    send_exp({8{16'h8000}}, {8{16'h8000}}, 1, 1, 1, {4{32'h40000000}},
             "R7 half signed min");
    idle(2);
    // mixed random, all mode combinations, back to back
    for (int r = 0; r < 6; r++) begin
      for (int m = 0; m < 8; m++) begin
        send({$urandom, $urandom, $urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom},
             m[2], m[1], m[0], "R3 R4 R5 R6 random lanes");
      end
      idle(2);
    end
    idle(3);
    check(exp_q.size() == 0, "R8 all results delivered",
          128'(exp_q.size()), '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule